// File: doc/BRIEF.md
# Triggered DMA request burst generator

This block is a single channel of a DMA request generator. It follows one trigger line, chosen from a bank of up to 32 inputs by a 5-bit select field. Each edge of the chosen line that matches the programmed edge sense starts a burst. A burst is a programmed number of DMA requests, issued one after another. Every request stays asserted until the DMA side returns a one-cycle acknowledge.

The channel is set up through one 32-bit control word. The word carries an enable bit, an edge-sense field, a request-count field, an overrun interrupt enable and the trigger select. A trigger edge that arrives while a burst is still running is dropped. That event sets a sticky overrun flag, and the flag can raise an interrupt. Software clears the flag with a one-cycle pulse.

Top module: `trig_burst_gen`

## Requirements
- R1: The stored control word reads back on `cfg_rdata` with the count-minus-one field at bits 23:19, the edge sense at 18:17, enable at 16, overrun interrupt enable at 8 and the trigger select at 4:0. Every other bit reads as 0, and the whole word is 0 after reset.
- R2: Each accepted trigger edge produces exactly count+1 acknowledged requests, so a burst holds from 1 to 32 requests.
- R3: The edge-sense code works as follows: 00 ignores the trigger, 01 reacts to rising edges, 10 to falling edges and 11 to both.
- R4: While the stored enable is 0, `dma_req` stays low. A write that clears enable during a burst drops `dma_req` and empties the remaining-request count at the same clock edge that stores the write. A later trigger then starts a full-length burst.
- R5: Only the trigger input whose index equals the select field can start a burst.
- R6: A write leaves the count field unchanged if the stored enable is 1 when the write happens. The other fields are written normally.
- R7: The trigger passes through two synchronizing flops before edge detection. A level change on the trigger that is first sampled at clock edge n raises `dma_req` after edge n+2.
- R8: A request stays high until `dma_ack` is seen together with it. The next cycle `dma_req` is low. If requests remain, `dma_req` rises again on the cycle after that.
- R9: An accepted edge that arrives while a burst is active (requesting or in the gap between requests) is dropped and sets `ovr_flag`. The flag stays set until an `ovr_clr` pulse. If a new overrun and a clear arrive in the same cycle, the set wins.
- R10: `ovr_irq` is high exactly when `ovr_flag` is set and the overrun interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Stored control word |
| trig | input | NTRIG | Trigger input bank |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | One-cycle DMA acknowledge |
| ovr_clr | input | 1 | One-cycle overrun flag clear |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The hardest situation to reach is an overrun. It needs a second accepted edge to pass the synchronizer while a burst is still running, and only then can the dropped-edge count and the flag priority be seen. The stimulus sets the longest burst (32 requests), slows the acknowledge to one every few cycles, and uses both-edge sense. The falling edge of a short trigger pulse then lands inside the burst. A second case clears the enable partway through a long burst, to show that the counter restarts in full on the next trigger.

// File: rtl/trg_pkg.sv
package trg_pkg;
    localparam int CFG_W     = 32;
    localparam int CNT_W     = 5;
    localparam int SEL_W     = 5;
    localparam int CNT_LSB   = 19;
    localparam int POL_LSB   = 17;
    localparam int EN_BIT    = 16;
    localparam int OIE_BIT   = 8;
    localparam int SEL_LSB   = 0;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } pol_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        pol_e             pol;
        logic             en;
        logic             oie;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    typedef enum logic [1:0] {
        BST_IDLE = 2'd0,
        BST_REQ  = 2'd1,
        BST_GAP  = 2'd2
    } bst_e;
endpackage

// File: rtl/trg_cfg_reg.sv
module trg_cfg_reg
    import trg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic             en_next,
    output logic [CFG_W-1:0] rdata
);
    typedef struct packed {
        cfg_t cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            // the count field is frozen while the channel runs
            if (!st_q.cfg.en) begin
                st_d.cfg.cnt = wdata[CNT_LSB +: CNT_W];
            end
            st_d.cfg.pol = pol_e'(wdata[POL_LSB +: 2]);
            st_d.cfg.en  = wdata[EN_BIT];
            st_d.cfg.oie = wdata[OIE_BIT];
            st_d.cfg.sel = wdata[SEL_LSB +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg     = st_q.cfg;
    assign en_next = st_d.cfg.en;

    always_comb begin
        rdata                      = '0;
        rdata[CNT_LSB +: CNT_W]    = st_q.cfg.cnt;
        rdata[POL_LSB +: 2]        = st_q.cfg.pol;
        rdata[EN_BIT]              = st_q.cfg.en;
        rdata[OIE_BIT]             = st_q.cfg.oie;
        rdata[SEL_LSB +: SEL_W]    = st_q.cfg.sel;
    end
endmodule

// File: rtl/trg_edge_det.sv
module trg_edge_det
    import trg_pkg::*;
#(
    parameter int NTRIG       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig,
    input  logic [SEL_W-1:0] sel,
    input  pol_e             pol,
    input  logic             en,
    output logic             edge_hit
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int HIST_W = SYNC_STAGES + 1;

    logic [NSEL-1:0]   trig_pad;
    logic              trig_sel;
    logic [HIST_W-1:0] hist_d, hist_q;
    logic              cur, prev, rise, fall;

    generate
        for (genvar i = 0; i < NSEL; i++) begin : g_pad
            if (i < NTRIG) begin : g_live
                assign trig_pad[i] = trig[i];
            end else begin : g_tie
                assign trig_pad[i] = 1'b0;
            end
        end
    endgenerate

    assign trig_sel = trig_pad[sel];

    always_comb begin
        hist_d = {hist_q[HIST_W-2:0], trig_sel};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign cur  = hist_q[SYNC_STAGES-1];
    assign prev = hist_q[SYNC_STAGES];
    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    always_comb begin
        unique case (pol)
            POL_RISE: edge_hit = en & rise;
            POL_FALL: edge_hit = en & fall;
            POL_BOTH: edge_hit = en & (rise | fall);
            default:  edge_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/trg_burst_eng.sv
module trg_burst_eng
    import trg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_next,
    input  logic [CNT_W-1:0] cnt,
    input  logic             edge_hit,
    input  logic             ack,
    input  logic             clr,
    output logic             req,
    output logic             flag
);
    typedef struct packed {
        bst_e             st;
        logic [CNT_W-1:0] rem;
        logic             flag;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (edge_hit && e_q.st != BST_IDLE) begin
            e_d.flag = 1'b1;
        end else if (clr) begin
            e_d.flag = 1'b0;
        end

        if (!en_next) begin
            e_d.st  = BST_IDLE;
            e_d.rem = '0;
        end else begin
            unique case (e_q.st)
                BST_IDLE: begin
                    if (edge_hit) begin
                        e_d.st  = BST_REQ;
                        e_d.rem = cnt;
                    end
                end
                BST_REQ: begin
                    if (ack) begin
                        if (e_q.rem == '0) begin
                            e_d.st = BST_IDLE;
                        end else begin
                            e_d.rem = e_q.rem - 1'b1;
                            e_d.st  = BST_GAP;
                        end
                    end
                end
                BST_GAP: e_d.st = BST_REQ;
                default: e_d.st = BST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{st: BST_IDLE, rem: '0, flag: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign req  = (e_q.st == BST_REQ);
    assign flag = e_q.flag;
endmodule

// File: rtl/trig_burst_gen.sv
module trig_burst_gen
    import trg_pkg::*;
#(
    parameter int NTRIG       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic [NTRIG-1:0] trig,
    output logic             dma_req,
    input  logic             dma_ack,
    input  logic             ovr_clr,
    output logic             ovr_flag,
    output logic             ovr_irq
);
    cfg_t cfg;
    logic en_next;
    logic edge_hit;

    trg_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .cfg     (cfg),
        .en_next (en_next),
        .rdata   (cfg_rdata)
    );

    trg_edge_det #(
        .NTRIG       (NTRIG),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .sel      (cfg.sel),
        .pol      (cfg.pol),
        .en       (cfg.en),
        .edge_hit (edge_hit)
    );

    trg_burst_eng u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_next  (en_next),
        .cnt      (cfg.cnt),
        .edge_hit (edge_hit),
        .ack      (dma_ack),
        .clr      (ovr_clr),
        .req      (dma_req),
        .flag     (ovr_flag)
    );

    assign ovr_irq = ovr_flag & cfg.oie;
endmodule

// File: rtl/trg_burst_chk.sv
module trg_burst_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        dma_req,
    input logic        dma_ack,
    input logic        ovr_clr,
    input logic        ovr_flag,
    input logic        ovr_irq
);
    localparam logic [31:0] RSV_MASK = 32'hFF00_FEE0;

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & RSV_MASK) == 32'h0);

    assert_no_req_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[16] |-> !dma_req);

    assert_cnt_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[16] |=> cfg_rdata[23:19] == $past(cfg_rdata[23:19]));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && !(cfg_wr && !cfg_wdata[16])) |=> dma_req);

    assert_gap_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_irq |-> ovr_flag);
endmodule

bind trig_burst_gen trg_burst_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .dma_req   (dma_req),
    .dma_ack   (dma_ack),
    .ovr_clr   (ovr_clr),
    .ovr_flag  (ovr_flag),
    .ovr_irq   (ovr_irq)
);

// File: tb/sim_trig_burst_gen.sv
`timescale 1ns/1ps
module sim_trig_burst_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] trig = '0;
    logic        dma_req;
    logic        dma_ack;
    logic        ovr_clr = 1'b0;
    logic        ovr_flag;
    logic        ovr_irq;

    logic auto_ack = 1'b1;
    logic auto_ack_r = 1'b0;
    logic man_ack = 1'b0;
    int   ack_dly = 0;
    int   ack_wait = 0;

    int checks = 0;
    int errors = 0;
    int hs = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_h0, m_h1, m_h2;
    int m_cnt, m_pol, m_en, m_oie, m_sel;
    int m_st, m_rem, m_flag;
    int t_v, er, ef, hit, nen;

    always #5 clk = ~clk;

    assign dma_ack = auto_ack ? auto_ack_r : man_ack;

    trig_burst_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .trig      (trig),
        .dma_req   (dma_req),
        .dma_ack   (dma_ack),
        .ovr_clr   (ovr_clr),
        .ovr_flag  (ovr_flag),
        .ovr_irq   (ovr_irq)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // acknowledge driver (auto mode)
    always @(negedge clk) begin
        if (auto_ack && dma_req && !auto_ack_r) begin
            if (ack_wait >= ack_dly) begin
                auto_ack_r <= 1'b1;
                ack_wait = 0;
            end else begin
                ack_wait++;
            end
        end else begin
            auto_ack_r <= 1'b0;
        end
    end

    // behavioural reference model
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        if (!rst_n) begin
            m_h0 = 0; m_h1 = 0; m_h2 = 0;
            m_cnt = 0; m_pol = 0; m_en = 0; m_oie = 0; m_sel = 0;
            m_st = 0; m_rem = 0; m_flag = 0;
        end else begin
            if (dma_req && dma_ack) hs++;
            t_v = int'(trig[m_sel]);
            er  = (m_h1 == 1 && m_h2 == 0) ? 1 : 0;
            ef  = (m_h1 == 0 && m_h2 == 1) ? 1 : 0;
            hit = (m_en == 1 && ((m_pol == 1 && er == 1) || (m_pol == 2 && ef == 1) ||
                                 (m_pol == 3 && (er == 1 || ef == 1)))) ? 1 : 0;
            nen = cfg_wr ? int'(cfg_wdata[16]) : m_en;
            if (hit == 1 && m_st != 0) m_flag = 1;
            else if (ovr_clr) m_flag = 0;
            if (nen == 0) begin
                m_st = 0; m_rem = 0;
            end else if (m_st == 0) begin
                if (hit == 1) begin m_st = 1; m_rem = m_cnt; end
            end else if (m_st == 1) begin
                if (dma_ack) begin
                    if (m_rem == 0) m_st = 0;
                    else begin m_rem--; m_st = 2; end
                end
            end else begin
                m_st = 1;
            end
            if (cfg_wr) begin
                if (m_en == 0) m_cnt = int'(cfg_wdata[23:19]);
                m_pol = int'(cfg_wdata[18:17]);
                m_en  = int'(cfg_wdata[16]);
                m_oie = int'(cfg_wdata[8]);
                m_sel = int'(cfg_wdata[4:0]);
            end
            m_h2 = m_h1; m_h1 = m_h0; m_h0 = t_v;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 req", int'(dma_req), (m_st == 1) ? 1 : 0);
            chk("R9 flag", int'(ovr_flag), m_flag);
            chk("R10 irq", int'(ovr_irq), (m_flag == 1 && m_oie == 1) ? 1 : 0);
            chk("R1 cfg", int'(cfg_rdata),
                (m_cnt << 19) | (m_pol << 17) | (m_en << 16) | (m_oie << 8) | m_sel);
        end
    end

    task automatic wr_cfg(int cnt, int pol, int en, int oie, int sel);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = (cnt << 19) | (pol << 17) | (en << 16) | (oie << 8) | sel;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic pulse(int idx, int width, int settle);
        @(negedge clk);
        trig[idx] = 1'b1;
        repeat (width) @(negedge clk);
        trig[idx] = 1'b0;
        repeat (settle) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 / R4: reset state
        chk("R1 reset word", int'(cfg_rdata), 0);
        chk("R4 reset req", int'(dma_req), 0);
        chk("R9 reset flag", int'(ovr_flag), 0);
        rst_n = 1'b1;

        // R4: disabled channel ignores triggers
        wr_cfg(3, 1, 0, 1, 5);
        hs = 0; pulse(5, 6, 30);
        chk("R4 disabled no requests", hs, 0);

        // R2 / R3: rising sense, 4 requests
        wr_cfg(3, 1, 1, 1, 5);
        hs = 0; pulse(5, 6, 40);
        chk("R2 burst of cnt+1 (rise)", hs, 4);

        // R5: other input has no effect, then reselect
        hs = 0; pulse(6, 6, 30);
        chk("R5 unselected input ignored", hs, 0);
        wr_cfg(3, 1, 1, 1, 6);
        hs = 0; pulse(6, 6, 40);
        chk("R5 selected input index 6", hs, 4);

        // R3: falling sense, count 0
        wr_cfg(3, 1, 0, 1, 6);
        wr_cfg(0, 2, 1, 1, 6);
        hs = 0;
        pulse(6, 20, 0);
        chk("R3 falling sense no burst on rise", hs, 0);
        repeat (20) @(negedge clk);
        chk("R3 falling sense single request", hs, 1);

        // R3: both edges, count 1 -> 2 bursts of 2
        wr_cfg(0, 2, 0, 1, 6);
        wr_cfg(1, 3, 1, 1, 6);
        hs = 0; pulse(6, 20, 30);
        chk("R3 both edges", hs, 4);

        // R3: sense 00 generates nothing
        wr_cfg(1, 0, 1, 1, 6);
        hs = 0; pulse(6, 20, 30);
        chk("R3 sense none", hs, 0);

        // R6: count write ignored while enabled
        wr_cfg(7, 1, 1, 1, 6);
        chk("R6 count frozen readback", int'(cfg_rdata[23:19]), 1);
        hs = 0; pulse(6, 6, 40);
        chk("R6 burst keeps old count", hs, 2);

        // R7 / R8: latency and handshake with manual acks
        wr_cfg(1, 1, 0, 1, 5);
        wr_cfg(1, 1, 1, 1, 5);
        auto_ack = 1'b0;
        @(negedge clk);
        trig[5] = 1'b1;
        @(negedge clk); chk("R7 req low after edge n", int'(dma_req), 0);
        @(negedge clk); chk("R7 req low after edge n+1", int'(dma_req), 0);
        @(negedge clk); chk("R7 req high after edge n+2", int'(dma_req), 1);
        repeat (5) @(negedge clk);
        chk("R8 req held without ack", int'(dma_req), 1);
        man_ack = 1'b1;
        @(negedge clk); man_ack = 1'b0;
        chk("R8 gap cycle after ack", int'(dma_req), 0);
        @(negedge clk); chk("R8 next request raised", int'(dma_req), 1);
        man_ack = 1'b1;
        @(negedge clk); man_ack = 1'b0;
        trig[5] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 burst ends after last ack", int'(dma_req), 0);
        auto_ack = 1'b1;

        // R9 / R10: overrun during long slow burst
        wr_cfg(1, 1, 0, 1, 5);
        wr_cfg(31, 3, 1, 1, 5);
        ack_dly = 2;
        hs = 0; pulse(5, 8, 200);
        chk("R9 dropped edge, burst length kept", hs, 32);
        chk("R9 overrun flag set", int'(ovr_flag), 1);
        chk("R10 irq with enable", int'(ovr_irq), 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk("R9 flag cleared", int'(ovr_flag), 0);
        wr_cfg(31, 3, 1, 0, 5);
        hs = 0; pulse(5, 8, 200);
        chk("R9 flag set again", int'(ovr_flag), 1);
        chk("R10 irq masked", int'(ovr_irq), 0);
        ack_dly = 0;

        // R4: disable mid burst drops at once, counter restarts in full
        wr_cfg(31, 1, 1, 1, 5);
        pulse(5, 4, 10);
        chk("R4 burst running", int'(dma_req | (m_st == 2)), 1);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = (31 << 19) | (1 << 17) | 5;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R4 req dropped at disable edge", int'(dma_req), 0);
        wr_cfg(31, 1, 1, 1, 5);
        repeat (10) @(negedge clk);
        chk("R4 no leftover requests", int'(dma_req), 0);
        hs = 0; pulse(5, 4, 90);
        chk("R4 full burst after restart", hs, 32);

        finish_run();
    end
endmodule